// File: doc/BRIEF.md
# UART Register Front End with Interrupt Logic

This block is the bus-facing register file of a small UART. A host talks to it over a plain synchronous request interface with an 8-bit data path and a 6-bit byte address. The block keeps the configuration bytes itself: two mode bytes, the interrupt mask and two baud-divisor bytes. It mirrors the line status reported by its companion blocks. From these it builds an interrupt status byte and drives one level-sensitive interrupt line.

The two mode bytes sit behind a single address. A hidden pointer starts at the first byte and moves to the second after any write. It goes back to the first byte only when the command decoder sends a pointer-clear pulse. One mode bit chooses the receive interrupt source: either the receive FIFO being full, or at least one byte being ready. Accesses to the data and command offsets are passed on as one-cycle strobes to the receive FIFO, the transmit path and the command decoder. Registers that belong to other logic (clock select, auxiliary control, input-port change) are read as zero, and writes to them are dropped.

Top module: `uart_regfront`

## Requirements
- R1: Synchronous reset clears both mode bytes, the mask, both baud bytes, the break flag and the read-data register. It also clears the mode pointer to the first byte and drives irq low. The mirrored status byte resets to 0x08, with only the transmitter-empty bit set.
- R2: At offset 0x00, a write stores the byte in the mode register chosen by the pointer and then sets the pointer to the second byte. A read returns the chosen byte and leaves the pointer unchanged. A pulse on mr_ptr_clr sets the pointer back to the first byte.
- R3: bus_rdata shows the read value on the cycle after the request edge. Offset 0x04 returns the status byte, which is stat_in registered once. The status bits are: bit0 receiver ready, bit1 FIFO full, bit2 transmitter ready, bit3 transmitter empty.
- R4: Bit 0 of the interrupt status byte (read at 0x14) equals status bit2 (transmitter ready).
- R5: Bit 1 of the interrupt status byte equals status bit1 (FIFO full) when bit 6 of mode byte 0 is 1. Otherwise it equals status bit0 (receiver ready).
- R6: Bit 2 of the interrupt status byte is a sticky break flag. A brk_evt pulse sets it, and a dbrk_clr pulse clears it. If both pulses arrive in the same cycle, the flag stays set.
- R7: Bit 7 of the interrupt status byte follows cos_in, registered once. Bits 3 to 6 read as zero.
- R8: irq is high exactly when the bitwise AND of the interrupt status byte and the mask is nonzero. A write to 0x14 sets the mask. irq follows register changes one cycle later.
- R9: A read of 0x0C returns rx_data and pulses rx_pop for exactly one cycle, on the cycle after the request.
- R10: A write to 0x0C pulses tx_push for one cycle and presents the byte on tx_data. A write to 0x08 does the same on cmd_we and cmd_data.
- R11: Reads of 0x10 and of any unmapped offset return 0. Writes to 0x04, 0x10 and unmapped offsets change no register, including the mode pointer.
- R12: Offsets 0x18 and 0x1C hold two baud bytes that read back the value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 1 | Level interrupt |
| stat_in | input | 8 | Line status from companion blocks |
| rx_data | input | 8 | Head byte of receive FIFO |
| rx_pop | output | 1 | Receive FIFO pop strobe |
| tx_push | output | 1 | Transmit byte strobe |
| tx_data | output | 8 | Transmit byte |
| cmd_we | output | 1 | Command strobe |
| cmd_data | output | 8 | Command byte |
| mr_ptr_clr | input | 1 | Pulse: mode pointer back to first byte |
| brk_evt | input | 1 | Pulse: break received |
| dbrk_clr | input | 1 | Pulse: clear break flag |
| cos_in | input | 1 | Change-of-state level |

## Verification
A wrong mode pointer shows up on the very next read of offset 0x00 as the other mode byte. A wrong receive-source selection shows up one cycle after a status change, either as a wrong bit 1 in the interrupt status byte or as an irq level that disagrees with the mask. A lost or stuck break flag is visible at 0x14 and on irq within two cycles of the pulse. A strobe routed to the wrong companion block appears on the wrong output in the cycle right after the request.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;
  localparam int OFF_W = 6;
  localparam logic [OFF_W-1:0] OFF_MODE  = 6'h00;
  localparam logic [OFF_W-1:0] OFF_STAT  = 6'h04;
  localparam logic [OFF_W-1:0] OFF_CMD   = 6'h08;
  localparam logic [OFF_W-1:0] OFF_DATA  = 6'h0C;
  localparam logic [OFF_W-1:0] OFF_AUX   = 6'h10;
  localparam logic [OFF_W-1:0] OFF_INT   = 6'h14;
  localparam logic [OFF_W-1:0] OFF_BAUD0 = 6'h18;
  localparam logic [OFF_W-1:0] OFF_BAUD1 = 6'h1C;

  // status bit positions
  localparam int ST_RXRDY = 0;
  localparam int ST_FFULL = 1;
  localparam int ST_TXRDY = 2;
  localparam int ST_TXEMP = 3;

  // interrupt status bit positions
  localparam int IS_TX  = 0;
  localparam int IS_RX  = 1;
  localparam int IS_BRK = 2;
  localparam int IS_COS = 7;

  typedef enum logic [3:0] {
    SEL_MODE, SEL_STAT, SEL_CMD, SEL_DATA, SEL_AUX,
    SEL_INT, SEL_BAUD0, SEL_BAUD1, SEL_NONE
  } reg_sel_e;
endpackage

// File: rtl/uart_rf_decode.sv
module uart_rf_decode
  import uart_rf_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  always_comb begin
    sel = SEL_NONE;
    if (addr == ADDR_W'(OFF_MODE))       sel = SEL_MODE;
    else if (addr == ADDR_W'(OFF_STAT))  sel = SEL_STAT;
    else if (addr == ADDR_W'(OFF_CMD))   sel = SEL_CMD;
    else if (addr == ADDR_W'(OFF_DATA))  sel = SEL_DATA;
    else if (addr == ADDR_W'(OFF_AUX))   sel = SEL_AUX;
    else if (addr == ADDR_W'(OFF_INT))   sel = SEL_INT;
    else if (addr == ADDR_W'(OFF_BAUD0)) sel = SEL_BAUD0;
    else if (addr == ADDR_W'(OFF_BAUD1)) sel = SEL_BAUD1;
  end
endmodule

// File: rtl/uart_rf_mode.sv
module uart_rf_mode #(
  parameter int DATA_W = 8,
  parameter int N_MODE = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ptr_clr,
  output logic [DATA_W-1:0] mode0,
  output logic [DATA_W-1:0] mode_rd,
  output logic              ptr
);
  logic [DATA_W-1:0] mr_q [N_MODE];

  for (genvar i = 0; i < N_MODE; i++) begin : g_mr
    always_ff @(posedge clk) begin
      if (rst)
        mr_q[i] <= '0;
      else if (wr_en && (int'(ptr) == i))
        mr_q[i] <= wdata;
    end
  end

  // a write moves the pointer forward and wins over a same-cycle clear
  always_ff @(posedge clk) begin
    if (rst)          ptr <= 1'b0;
    else if (wr_en)   ptr <= 1'b1;
    else if (ptr_clr) ptr <= 1'b0;
  end

  assign mode0   = mr_q[0];
  assign mode_rd = mr_q[ptr];
endmodule

// File: rtl/uart_rf_irq.sv
module uart_rf_irq
  import uart_rf_pkg::*;
#(
  parameter int              DATA_W    = 8,
  parameter int              RXSEL_BIT = 6,
  parameter logic [DATA_W-1:0] STAT_RST = 8'h08
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] stat_in,
  input  logic [DATA_W-1:0] mode0,
  input  logic              brk_evt,
  input  logic              dbrk_clr,
  input  logic              cos_in,
  input  logic              imr_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] stat_q,
  output logic [DATA_W-1:0] isr,
  output logic [DATA_W-1:0] imr_q,
  output logic              dbrk_q,
  output logic              irq
);
  logic cos_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= STAT_RST;
      cos_q  <= 1'b0;
      imr_q  <= '0;
      dbrk_q <= 1'b0;
    end else begin
      stat_q <= stat_in;
      cos_q  <= cos_in;
      if (imr_we) imr_q <= wdata;
      if (brk_evt)       dbrk_q <= 1'b1;
      else if (dbrk_clr) dbrk_q <= 1'b0;
    end
  end

  always_comb begin
    isr         = '0;
    isr[IS_TX]  = stat_q[ST_TXRDY];
    isr[IS_RX]  = mode0[RXSEL_BIT] ? stat_q[ST_FFULL] : stat_q[ST_RXRDY];
    isr[IS_BRK] = dbrk_q;
    isr[IS_COS] = cos_q;
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(isr & imr_q);
  end
endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
  import uart_rf_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 8,
  parameter int RXSEL_BIT = 6,
  parameter int N_BAUD    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  input  logic [DATA_W-1:0] stat_in,
  input  logic [DATA_W-1:0] rx_data,
  output logic              rx_pop,
  output logic              tx_push,
  output logic [DATA_W-1:0] tx_data,
  output logic              cmd_we,
  output logic [DATA_W-1:0] cmd_data,
  input  logic              mr_ptr_clr,
  input  logic              brk_evt,
  input  logic              dbrk_clr,
  input  logic              cos_in
);
  localparam logic [DATA_W-1:0] STAT_RST = DATA_W'(1) << ST_TXEMP;

  reg_sel_e          sel;
  logic              wr, rd;
  logic [DATA_W-1:0] mode0, mode_rd, stat_q, isr, imr_q;
  logic              dbrk_q, mr_ptr;
  logic [DATA_W-1:0] baud_q [N_BAUD];
  logic [DATA_W-1:0] rd_mux;

  assign wr = bus_valid &  bus_we;
  assign rd = bus_valid & ~bus_we;

  uart_rf_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  uart_rf_mode #(.DATA_W(DATA_W), .N_MODE(2)) u_mode (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr && sel == SEL_MODE),
    .wdata   (bus_wdata),
    .ptr_clr (mr_ptr_clr),
    .mode0   (mode0),
    .mode_rd (mode_rd),
    .ptr     (mr_ptr)
  );

  uart_rf_irq #(.DATA_W(DATA_W), .RXSEL_BIT(RXSEL_BIT), .STAT_RST(STAT_RST)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .stat_in  (stat_in),
    .mode0    (mode0),
    .brk_evt  (brk_evt),
    .dbrk_clr (dbrk_clr),
    .cos_in   (cos_in),
    .imr_we   (wr && sel == SEL_INT),
    .wdata    (bus_wdata),
    .stat_q   (stat_q),
    .isr      (isr),
    .imr_q    (imr_q),
    .dbrk_q   (dbrk_q),
    .irq      (irq)
  );

  for (genvar b = 0; b < N_BAUD; b++) begin : g_baud
    localparam reg_sel_e BSEL = (b == 0) ? SEL_BAUD0 : SEL_BAUD1;
    always_ff @(posedge clk) begin
      if (rst)                    baud_q[b] <= '0;
      else if (wr && sel == BSEL) baud_q[b] <= bus_wdata;
    end
  end

  always_comb begin
    case (sel)
      SEL_MODE:  rd_mux = mode_rd;
      SEL_STAT:  rd_mux = stat_q;
      SEL_DATA:  rd_mux = rx_data;
      SEL_INT:   rd_mux = isr;
      SEL_BAUD0: rd_mux = baud_q[0];
      SEL_BAUD1: rd_mux = baud_q[N_BAUD-1];
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      rx_pop    <= 1'b0;
      tx_push   <= 1'b0;
      cmd_we    <= 1'b0;
      tx_data   <= '0;
      cmd_data  <= '0;
    end else begin
      if (rd) bus_rdata <= rd_mux;
      rx_pop  <= rd && sel == SEL_DATA;
      tx_push <= wr && sel == SEL_DATA;
      cmd_we  <= wr && sel == SEL_CMD;
      if (wr && sel == SEL_DATA) tx_data  <= bus_wdata;
      if (wr && sel == SEL_CMD)  cmd_data <= bus_wdata;
    end
  end
endmodule

// File: rtl/uart_regfront_chk.sv
module uart_regfront_chk #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_valid,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              irq,
  input logic              rx_pop,
  input logic              tx_push,
  input logic              cmd_we,
  input logic [DATA_W-1:0] imr_q,
  input logic              dbrk_q,
  input logic              dbrk_clr,
  input logic              mr_ptr
);
  AST_IRQ_LOW_AFTER_RST: assert property (@(posedge clk) $past(rst) |-> !irq); // R1

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    ($past(imr_q) == '0 && !$past(rst)) |-> !irq); // R8

  AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    $past(bus_valid && bus_we && bus_addr == ADDR_W'(0)) |-> mr_ptr); // R2

  AST_BRK_STICKY: assert property (@(posedge clk) disable iff (rst)
    ($past(dbrk_q) && !$past(dbrk_clr) && !$past(rst)) |-> dbrk_q); // R6

  AST_POP_SOURCE: assert property (@(posedge clk) disable iff (rst)
    rx_pop |-> $past(bus_valid && !bus_we && bus_addr == ADDR_W'(12))); // R9

  AST_PUSH_SOURCE: assert property (@(posedge clk) disable iff (rst)
    tx_push |-> $past(bus_valid && bus_we && bus_addr == ADDR_W'(12))); // R10

  AST_CMD_SOURCE: assert property (@(posedge clk) disable iff (rst)
    cmd_we |-> $past(bus_valid && bus_we && bus_addr == ADDR_W'(8))); // R10

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rx_pop, tx_push, cmd_we})); // R10
endmodule

bind uart_regfront uart_regfront_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_valid (bus_valid),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .irq       (irq),
  .rx_pop    (rx_pop),
  .tx_push   (tx_push),
  .cmd_we    (cmd_we),
  .imr_q     (imr_q),
  .dbrk_q    (dbrk_q),
  .dbrk_clr  (dbrk_clr),
  .mr_ptr    (mr_ptr)
);

// File: tb/test_uart_regfront.sv
`timescale 1ns/1ps
module test_uart_regfront;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_valid = 1'b0, bus_we = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq;
  logic [7:0] stat_in = 8'h08;
  logic [7:0] rx_data = '0;
  logic       rx_pop, tx_push, cmd_we;
  logic [7:0] tx_data, cmd_data;
  logic       mr_ptr_clr = 1'b0, brk_evt = 1'b0, dbrk_clr = 1'b0, cos_in = 1'b0;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  uart_regfront i_uart_regfront (.*);

  typedef struct packed {
    logic       wr;
    logic [5:0] adr;
    logic [7:0] dat;
    logic [7:0] exp;
  } vec_t;

  // table walk covers R2, R3, R11, R12
  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 6'h04, 8'h00, 8'h08},  // R3 status after reset
    '{1'b0, 6'h00, 8'h00, 8'h00},  // R1 mode reset
    '{1'b1, 6'h00, 8'h5A, 8'h00},  // R2 mode byte 0
    '{1'b1, 6'h00, 8'hC3, 8'h00},  // R2 mode byte 1
    '{1'b0, 6'h00, 8'h00, 8'hC3},  // R2 pointer on byte 1
    '{1'b1, 6'h00, 8'h77, 8'h00},
    '{1'b0, 6'h00, 8'h00, 8'h77},
    '{1'b1, 6'h18, 8'h12, 8'h00},  // R12
    '{1'b1, 6'h1C, 8'h34, 8'h00},
    '{1'b0, 6'h18, 8'h00, 8'h12},
    '{1'b0, 6'h1C, 8'h00, 8'h34},
    '{1'b1, 6'h04, 8'hFF, 8'h00},  // R11 ignored writes
    '{1'b1, 6'h10, 8'hFF, 8'h00},
    '{1'b1, 6'h3F, 8'hFF, 8'h00},
    '{1'b0, 6'h00, 8'h00, 8'h77},  // R11 pointer and mode unchanged
    '{1'b0, 6'h10, 8'h00, 8'h00},  // R11 aux reads zero
    '{1'b0, 6'h3C, 8'h00, 8'h00},  // R11 unmapped reads zero
    '{1'b0, 6'h18, 8'h00, 8'h12},  // R11 baud unchanged
    '{1'b0, 6'h14, 8'h00, 8'h00}   // R11 mask still zero, isr zero
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [5:0] a, input logic [7:0] d);
    bus_valid = 1'b1; bus_we = w; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_in(input bit p, input bit b, input bit c);
    mr_ptr_clr = p; brk_evt = b; dbrk_clr = c;
    @(negedge clk);
    mr_ptr_clr = 0; brk_evt = 0; dbrk_clr = 0;
  endtask

  initial begin
    idle(3);
    chk("R1 rdata", bus_rdata, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    chk("R1 strobes", {5'b0, rx_pop, tx_push, cmd_we}, 8'h00);
    rst = 1'b0;
    idle(1);

    for (int i = 0; i < NV; i++) begin
      access(VECS[i].wr, VECS[i].adr, VECS[i].dat);
      if (!VECS[i].wr) chk($sformatf("table %0d", i), bus_rdata, VECS[i].exp);
    end

    // R2 pointer clear
    pulse_in(1, 0, 0);
    access(0, 6'h00, 0); chk("R2 after clear", bus_rdata, 8'h5A);
    access(0, 6'h00, 0); chk("R2 read keeps ptr", bus_rdata, 8'h5A);

    // R4
    stat_in = 8'h0C; idle(1);
    access(0, 6'h14, 0); chk("R4 txint", bus_rdata, 8'h01);

    // R8 mask and latency
    access(1, 6'h14, 8'h01);
    chk("R8 irq latency", {7'b0, irq}, 8'h00);
    idle(1); chk("R8 irq set", {7'b0, irq}, 8'h01);
    access(1, 6'h14, 8'h02); idle(1);
    chk("R8 irq masked", {7'b0, irq}, 8'h00);

    // R5 source from FIFO full (mode0 bit6 = 1)
    stat_in = 8'h0D; idle(1);
    access(0, 6'h14, 0); chk("R5 rxrdy ignored", bus_rdata, 8'h01);
    stat_in = 8'h0F; idle(1);
    access(0, 6'h14, 0); chk("R5 ffull", bus_rdata, 8'h03);
    idle(1); chk("R8 irq rx", {7'b0, irq}, 8'h01);
    // R5 source from receiver ready (mode0 bit6 = 0)
    access(1, 6'h00, 8'h00);
    stat_in = 8'h09; idle(1);
    access(0, 6'h14, 0); chk("R5 rxrdy", bus_rdata, 8'h02);
    stat_in = 8'h0A; idle(1);
    access(0, 6'h14, 0); chk("R5 ffull ignored", bus_rdata, 8'h00);
    stat_in = 8'h09; idle(1);

    // R6 sticky break
    pulse_in(0, 1, 0);
    access(0, 6'h14, 0); chk("R6 set", bus_rdata, 8'h06);
    access(1, 6'h14, 8'h04);
    access(0, 6'h14, 0); chk("R6 sticky", bus_rdata, 8'h06);
    idle(1); chk("R6 irq", {7'b0, irq}, 8'h01);
    pulse_in(0, 1, 1);
    access(0, 6'h14, 0); chk("R6 set wins", bus_rdata, 8'h06);
    pulse_in(0, 0, 1);
    access(0, 6'h14, 0); chk("R6 clear", bus_rdata, 8'h02);
    idle(1); chk("R6 irq drop", {7'b0, irq}, 8'h00);

    // R7
    cos_in = 1; idle(1);
    access(0, 6'h14, 0); chk("R7 cos", bus_rdata, 8'h82);
    cos_in = 0; idle(1);
    access(0, 6'h14, 0); chk("R7 cos off", bus_rdata, 8'h02);

    // R9
    rx_data = 8'hA5;
    access(0, 6'h0C, 0);
    chk("R9 data", bus_rdata, 8'hA5);
    chk("R9 pop", {7'b0, rx_pop}, 8'h01);
    idle(1); chk("R9 pop once", {7'b0, rx_pop}, 8'h00);

    // R10
    access(1, 6'h0C, 8'h3C);
    chk("R10 push", {6'b0, tx_push, cmd_we}, 8'h02);
    chk("R10 tx byte", tx_data, 8'h3C);
    idle(1); chk("R10 push once", {7'b0, tx_push}, 8'h00);
    access(1, 6'h08, 8'h15);
    chk("R10 cmd", {6'b0, tx_push, cmd_we}, 8'h01);
    chk("R10 cmd byte", cmd_data, 8'h15);

    // R3 status mirror
    stat_in = 8'h0A; idle(1);
    access(0, 6'h04, 0); chk("R3 status", bus_rdata, 8'h0A);

    // R1 reset mid-run
    stat_in = 8'h08;
    rst = 1; idle(2); rst = 0;
    chk("R1 irq after rst", {7'b0, irq}, 8'h00);
    access(0, 6'h00, 0); chk("R1 mode cleared", bus_rdata, 8'h00);
    access(0, 6'h14, 0); chk("R1 isr cleared", bus_rdata, 8'h00);
    access(0, 6'h1C, 0); chk("R1 baud cleared", bus_rdata, 8'h00);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule